// File: doc/BRIEF.md
# SDRAM Periodic Auto-Refresh Timer

This block paces the auto-refresh traffic of an SDRAM controller. A down-counter is reloaded from a refresh interval that software loads as a count of clock cycles. Each time the counter expires it raises a refresh request. At 100 MHz, typical interval values are 1562 cycles (15.625 µs) or 781 cycles (7.81 µs). The request is granted only when the access sequencer reports that it is idle. A request that arrives during a burst is held until that burst finishes.

Once the request is granted, the block runs a fixed refresh phase and raises a stall towards the access path for the whole phase. The phase is a precharge window of tRP cycles followed by an auto-refresh window of tRC cycles. A precharge-all strobe is issued at the start of the phase if any row is open. The auto-refresh strobe is issued at the start of the second window. The auto-refresh command carries no row address, because the memory steps its own refresh row. An interval of zero turns the timer off.

Top module: `sdram_refresh_timer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `stall`, `auto_ref` and `pre_all` are all 0.
- R2: With a nonzero interval N and the access path idle, a refresh is granted on every Nth rising edge after reset release. Counting the first edge after release as edge 0, the grants fall on edges N, 2N, 3N and so on. `auto_ref` is high for the one cycle that follows edge kN+TRP.
- R3: With an interval of 0, no refresh is ever requested: `stall`, `auto_ref` and `pre_all` stay 0.
- R4: Each refresh phase holds `stall` high for exactly TRP+TRC consecutive cycles. `auto_ref` pulses once, TRP cycles after `stall` rises. `auto_ref` and `pre_all` are never high together.
- R5: `pre_all` pulses for one cycle, in the first stall cycle, only if `rows_open` was 1 at the granting edge. Otherwise it stays 0.
- R6: While `acc_idle` is 0, no refresh phase starts. An expiry in that time is kept pending and is granted at the first edge at which `acc_idle` is 1.
- R7: The counter reloads at the moment it expires, not when the refresh completes. A deferred refresh therefore does not shift later refreshes, which still fall on edges that are multiples of N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rfsh_count | input | CNT_W | Refresh interval in clock cycles; 0 disables the timer |
| acc_idle | input | 1 | High when the access sequencer has no burst in flight |
| rows_open | input | 1 | High when at least one bank has an open row |
| pre_all | output | 1 | One-cycle precharge-all-banks request |
| auto_ref | output | 1 | One-cycle auto-refresh command strobe |
| stall | output | 1 | High during a refresh phase; holds off new accesses (busy) |

## Verification
The main function is tried with three patterns. An always-idle access path at two different intervals separates correct interval counting from an off-by-one reload. A run with `rows_open` low shows whether the precharge strobe is gated or unconditional. A busy window that covers an expiry distinguishes a pending request from a lost one. It also distinguishes reload-at-expiry from reload-at-completion, because the next refresh must stay on its N-cycle grid. A zero interval held for hundreds of cycles confirms that the timer is truly off.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_REF  = 2'd2
    } rfsh_phase_e;
endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = 1'b0;
        if (period == '0) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == CNT_W'(1)) begin
            expire    = 1'b1;
            tmr_d.cnt = period;      // reload on expiry, no drift
        end else if (tmr_q.cnt == '0) begin
            tmr_d.cnt = period;
        end else begin
            tmr_d.cnt = tmr_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (tmr_q.cnt == $past(period)));

    p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0) |=> !expire);
endmodule

// File: rtl/rfsh_phase_seq.sv
module rfsh_phase_seq
    import rfsh_pkg::*;
#(
    parameter int TRP = 2,
    parameter int TRC = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic acc_idle,
    input  logic rows_open,
    output logic pre_all,
    output logic auto_ref,
    output logic stall
);
    localparam int PH_MAX = (TRP > TRC) ? TRP : TRC;
    localparam int PH_W   = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] TRP_M1 = PH_W'(TRP - 1);
    localparam logic [PH_W-1:0] TRC_M1 = PH_W'(TRC - 1);

    typedef struct packed {
        rfsh_phase_e     ph;
        logic [PH_W-1:0] cnt;
        logic            pend;
        logic            pre_all;
        logic            auto_ref;
    } seq_st_t;

    seq_st_t seq_d, seq_q;
    logic    req;

    always_comb begin
        seq_d          = seq_q;
        seq_d.pre_all  = 1'b0;
        seq_d.auto_ref = 1'b0;
        req            = expire | seq_q.pend;
        seq_d.pend     = seq_q.pend | expire;
        case (seq_q.ph)
            PH_IDLE: begin
                if (req && acc_idle) begin
                    seq_d.ph      = PH_PRE;
                    seq_d.cnt     = TRP_M1;
                    seq_d.pre_all = rows_open;
                    seq_d.pend    = 1'b0;
                end
            end
            PH_PRE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.ph       = PH_REF;
                    seq_d.cnt      = TRC_M1;
                    seq_d.auto_ref = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - PH_W'(1);
                end
            end
            PH_REF: begin
                if (seq_q.cnt == '0) seq_d.ph  = PH_IDLE;
                else                 seq_d.cnt = seq_q.cnt - PH_W'(1);
            end
            default: seq_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{ph: PH_IDLE, default: '0};
        else        seq_q <= seq_d;
    end

    assign pre_all  = seq_q.pre_all;
    assign auto_ref = seq_q.auto_ref;
    assign stall    = (seq_q.ph != PH_IDLE);

    p_single_ref_r4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ref |=> !auto_ref);

    p_ref_stalled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        auto_ref |-> stall);

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(auto_ref && pre_all));

    p_pre_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pre_all |-> ($past(rows_open) && $rose(stall)));

    p_grant_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(acc_idle));

    p_pend_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && seq_q.pend && !acc_idle) |=> seq_q.pend);
endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int CNT_W = 16,
    parameter int TRP   = 2,
    parameter int TRC   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] rfsh_count,
    input  logic             acc_idle,
    input  logic             rows_open,
    output logic             pre_all,
    output logic             auto_ref,
    output logic             stall
);
    logic tick;

    rfsh_interval_timer #(.CNT_W(CNT_W)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .period (rfsh_count),
        .expire (tick)
    );

    rfsh_phase_seq #(.TRP(TRP), .TRC(TRC)) i_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .expire    (tick),
        .acc_idle  (acc_idle),
        .rows_open (rows_open),
        .pre_all   (pre_all),
        .auto_ref  (auto_ref),
        .stall     (stall)
    );

    p_rst_quiet_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!stall && !auto_ref && !pre_all));
endmodule

// File: tb/test_sdram_refresh_timer.sv
module test_sdram_refresh_timer;
    localparam int CNT_W = 16;
    localparam int TRP   = 2;
    localparam int TRC   = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [CNT_W-1:0] rfsh_count = '0;
    logic             acc_idle = 1'b1;
    logic             rows_open = 1'b0;
    logic             pre_all, auto_ref, stall;

    always #4 clk = ~clk;

    sdram_refresh_timer #(.CNT_W(CNT_W), .TRP(TRP), .TRC(TRC)) i_sdram_refresh_timer (
        .clk(clk), .rst_n(rst_n), .rfsh_count(rfsh_count), .acc_idle(acc_idle),
        .rows_open(rows_open), .pre_all(pre_all), .auto_ref(auto_ref), .stall(stall)
    );

    int    n_chk = 0, n_fail = 0;
    int    ev = -1;
    int    wd = 0;
    int    run_len = 0;
    int    ref_seen = 0, stall_seen = 0;
    int    mon_x;
    string mon_t;
    int    exp_ref[$];
    string exp_tag[$];
    int    exp_pre[$];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // edge index: first posedge after reset release is edge 0
    always @(posedge clk) begin
        if (!rst_n) ev <= -1;
        else        ev <= ev + 1;
    end

    // monitor: pops expected strobe edges and compares
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0;
        end else begin
            if (auto_ref) begin
                ref_seen++;
                if (exp_ref.size() == 0) chk(1'b0, "R2 unexpected auto_ref at edge", ev, -1);
                else begin
                    mon_x = exp_ref.pop_front();
                    mon_t = exp_tag.pop_front();
                    chk(mon_x == ev, mon_t, ev, mon_x);
                end
            end
            if (pre_all) begin
                if (exp_pre.size() == 0) chk(1'b0, "R5 unexpected pre_all at edge", ev, -1);
                else begin
                    mon_x = exp_pre.pop_front();
                    chk(mon_x == ev, "R5 pre_all edge", ev, mon_x);
                end
            end
            if (stall) begin
                run_len++;
                stall_seen++;
            end else if (run_len != 0) begin
                chk(run_len == TRP + TRC, "R4 stall length", run_len, TRP + TRC);
                run_len = 0;
            end
        end
    end

    task automatic wait_ev(input int n);
        while (ev != n) @(negedge clk);
    endtask

    task automatic push_ref(input int e, input string tag);
        exp_ref.push_back(e);
        exp_tag.push_back(tag);
    endtask

    task automatic start_run(input int cfg, input bit rows);
        @(negedge clk);
        chk(exp_ref.size() == 0, "R2 missing auto_ref count", exp_ref.size(), 0);
        chk(exp_pre.size() == 0, "R5 missing pre_all count", exp_pre.size(), 0);
        exp_ref.delete(); exp_tag.delete(); exp_pre.delete();
        rst_n      = 1'b0;
        rfsh_count = CNT_W'(cfg);
        rows_open  = rows;
        acc_idle   = 1'b1;
        repeat (3) @(negedge clk);
        chk(stall == 1'b0,    "R1 stall in reset", stall, 0);
        chk(auto_ref == 1'b0, "R1 auto_ref in reset", auto_ref, 0);
        chk(pre_all == 1'b0,  "R1 pre_all in reset", pre_all, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(stall == 1'b0, "R1 stall after reset", stall, 0);
    endtask

    initial begin
        // run 1: N=40, idle path, rows open
        start_run(40, 1'b1);
        push_ref(42, "R2 refresh edge N=40 k=1");
        push_ref(82, "R2 refresh edge N=40 k=2");
        push_ref(122, "R2 refresh edge N=40 k=3");
        exp_pre.push_back(40); exp_pre.push_back(80); exp_pre.push_back(120);
        wait_ev(130);

        // run 2: N=25, no rows open -> no precharge strobe
        start_run(25, 1'b0);
        push_ref(27, "R2 refresh edge N=25 k=1");
        push_ref(52, "R2 refresh edge N=25 k=2");
        push_ref(77, "R2 refresh edge N=25 k=3");
        wait_ev(80);

        // run 3: N=30, access busy across first expiry
        start_run(30, 1'b1);
        push_ref(38, "R6 deferred refresh edge");
        push_ref(62, "R7 refresh edge after deferral");
        push_ref(92, "R7 refresh edge k=3");
        exp_pre.push_back(36); exp_pre.push_back(60); exp_pre.push_back(90);
        wait_ev(27);
        acc_idle = 1'b0;
        wait_ev(30);
        chk(stall == 1'b0, "R6 no stall while access busy", stall, 0);
        wait_ev(35);
        chk(stall == 1'b0, "R6 no stall at end of access", stall, 0);
        acc_idle = 1'b1;
        wait_ev(36);
        chk(stall == 1'b1, "R6 pending refresh granted", stall, 1);
        wait_ev(95);

        // run 4: interval zero -> timer off
        start_run(0, 1'b1);
        ref_seen   = 0;
        stall_seen = 0;
        wait_ev(300);
        chk(ref_seen == 0,   "R3 auto_ref count with zero interval", ref_seen, 0);
        chk(stall_seen == 0, "R3 stall cycles with zero interval", stall_seen, 0);

        start_run(0, 1'b0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", wd, 20000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule